// File: doc/BRIEF.md
# Sectioned Register-Space Address Sequencer

This block steers accesses into a small clock and control register space that sits behind a serial byte bus. The bit-level bus engine sits in front of it and the register storage behind it. The bus engine reports a transaction start or stop, the device select byte, the address byte and one strobe per data byte. The sequencer answers with the register address for that byte, whether the byte is taken, and whether the operation has to be ended.

The 64-byte space holds five sections. A pointer moves through a section one byte at a time. When it passes the last byte of its section, it returns to that section's first byte. To reach another section, a new operation is needed. The single status byte allows only one data byte per operation, and it carries a two-step write-enable latch. Every other section refuses writes until both stages of that latch are set. The pointer is kept across operations, so a read that gives no address continues from where the previous access stopped.

Top module: `ctl_addr_seq`

## Requirements
- R1: A `sel_valid` strobe after `start` is acknowledged on `sel_ack` in the same cycle only if `sel_byte[7:1]` equals 7'b1101111. A non-matching byte is not acknowledged, and every strobe is then ignored until the next `start`. `sel_byte[0]`=1 selects a read from the current pointer, and 0 selects a write that takes an address byte next.
- R2: An address byte is accepted (`addr_ack` high in its strobe cycle) only inside one of these ranges: 0x00-0x07 (alarm 1, section code 1), 0x08-0x0F (alarm 0, code 0), 0x10-0x11 (control, code 2), 0x30-0x37 (clock, code 3) or 0x3F (status, code 4). Any other address is refused, and the rest of the operation is ignored.
- R3: `reg_addr` gives the pointer for the current data byte. After each data byte the pointer advances by one, and it returns to the first address of its own section when it passes the section's last address.
- R4: The pointer is kept between operations. A read operation starts at the address that follows the last byte accessed, and writing an address with no data byte sets that start point.
- R5: In the status section a second data strobe (read or write) in the same operation raises `term` in its cycle and is not accepted. The operation then ignores all further strobes and commits nothing.
- R6: When a one-byte status write ends with a stop, it updates the latch outputs. 0x02 sets `wel`, 0x06 sets `rwel` only if `wel` is already set, 0x00 clears both, and other values leave them unchanged. `rwel` is never set while `wel` is clear.
- R7: A write byte outside the status section is accepted (`wr_accept`) only when `wel` and `rwel` are both set. A refused byte still advances the pointer.
- R8: `commit` pulses for one cycle in the cycle after a `stop` that ends a write operation with at least one accepted byte, and `commit_sec` then holds that section's code. A `start` before the stop, a `term`, or no accepted byte gives no commit. A data strobe in the same cycle as `stop` is ignored.
- R9: After reset the pointer is 0x00, both latch bits are clear and `commit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | transaction start (also a repeated start) |
| stop | input | 1 | transaction stop |
| sel_valid | input | 1 | device select byte strobe |
| sel_byte | input | 8 | device select byte, bit 0 = read |
| addr_valid | input | 1 | address byte strobe |
| addr_in | input | 8 | address byte |
| wr_strobe | input | 1 | write data byte strobe |
| wr_data | input | 8 | write data byte |
| rd_strobe | input | 1 | read data byte strobe |
| reg_addr | output | 6 | register address for the current byte |
| sel_ack | output | 1 | select byte acknowledged |
| addr_ack | output | 1 | address byte acknowledged |
| wr_accept | output | 1 | write byte taken into the buffer |
| term | output | 1 | operation ended by a second status byte |
| commit | output | 1 | one-cycle buffer commit pulse |
| commit_sec | output | 3 | section code of the commit |
| wel | output | 1 | first write-enable latch stage |
| rwel | output | 1 | second write-enable latch stage |

## Verification
Two functions can fall in the same cycle: the stop that closes a write and decides the commit, and a data strobe that would move the pointer and add a byte. The bench raises `stop` and `wr_strobe` in one cycle after an address has been set. It then checks three things: no byte is accepted, no commit follows, and a later read still starts at the original address. A table of read walks crosses every section's wrap point. Directed sequences cover the order of the latch steps and the end of an operation on the status byte.

// File: rtl/ctl_addr_seq.sv
module ctl_addr_seq #(
  parameter logic [6:0] DEV_ID = 7'b1101111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stop,
  input  logic       sel_valid,
  input  logic [7:0] sel_byte,
  input  logic       addr_valid,
  input  logic [7:0] addr_in,
  input  logic       wr_strobe,
  input  logic [7:0] wr_data,
  input  logic       rd_strobe,
  output logic [5:0] reg_addr,
  output logic       sel_ack,
  output logic       addr_ack,
  output logic       wr_accept,
  output logic       term,
  output logic       commit,
  output logic [2:0] commit_sec,
  output logic       wel,
  output logic       rwel
);

  localparam logic [2:0] SEC_A0 = 3'd0, SEC_A1 = 3'd1, SEC_CT = 3'd2,
                         SEC_CK = 3'd3, SEC_ST = 3'd4, SEC_NO = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_ADDR, S_WR, S_RD, S_DEAD} st_t;

  function automatic logic [2:0] sec_of(input logic [7:0] a);
    if (a <= 8'h07) return SEC_A1;
    else if (a <= 8'h0F) return SEC_A0;
    else if (a <= 8'h11) return SEC_CT;
    else if (a >= 8'h30 && a <= 8'h37) return SEC_CK;
    else if (a == 8'h3F) return SEC_ST;
    else return SEC_NO;
  endfunction

  function automatic logic [5:0] base_of(input logic [2:0] s);
    case (s)
      SEC_A0:  return 6'h08;
      SEC_CT:  return 6'h10;
      SEC_CK:  return 6'h30;
      SEC_ST:  return 6'h3F;
      default: return 6'h00;
    endcase
  endfunction

  function automatic logic [5:0] last_of(input logic [2:0] s);
    case (s)
      SEC_A0:  return 6'h0F;
      SEC_CT:  return 6'h11;
      SEC_CK:  return 6'h37;
      SEC_ST:  return 6'h3F;
      default: return 6'h07;
    endcase
  endfunction

  st_t        st;
  logic [5:0] ptr;
  logic       used, acc;
  logic [7:0] stat_byte;

  logic [2:0] ptr_sec;
  logic [5:0] nxt;
  logic       quiet, is_stat, wstb, rstb;

  assign ptr_sec  = sec_of({2'b00, ptr});
  assign nxt      = (ptr == last_of(ptr_sec)) ? base_of(ptr_sec) : ptr + 6'd1;
  assign is_stat  = (ptr_sec == SEC_ST);
  assign quiet    = !start && !stop;
  assign reg_addr = ptr;

  assign sel_ack   = quiet && st == S_SEL && sel_valid && sel_byte[7:1] == DEV_ID;
  assign addr_ack  = quiet && st == S_ADDR && addr_valid && sec_of(addr_in) != SEC_NO;
  assign wstb      = quiet && st == S_WR && wr_strobe;
  assign rstb      = quiet && st == S_RD && rd_strobe;
  assign term      = (wstb || rstb) && is_stat && used;
  assign wr_accept = wstb && !term && (is_stat || (wel && rwel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ptr        <= 6'h00;
      used       <= 1'b0;
      acc        <= 1'b0;
      stat_byte  <= 8'h00;
      commit     <= 1'b0;
      commit_sec <= SEC_A0;
      wel        <= 1'b0;
      rwel       <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start) begin
        st   <= S_SEL;
        used <= 1'b0;
        acc  <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE;
        if (st == S_WR && acc) begin
          commit     <= 1'b1;
          commit_sec <= ptr_sec;
          if (is_stat) begin
            case (stat_byte)
              8'h00: begin wel <= 1'b0; rwel <= 1'b0; end
              8'h02: wel <= 1'b1;
              8'h06: if (wel) rwel <= 1'b1;
              default: ;
            endcase
          end
        end
      end else begin
        case (st)
          S_SEL: if (sel_valid)
            st <= sel_ack ? (sel_byte[0] ? S_RD : S_ADDR) : S_DEAD;
          S_ADDR: if (addr_valid) begin
            if (addr_ack) begin
              ptr <= addr_in[5:0];
              st  <= S_WR;
            end else st <= S_DEAD;
          end
          S_WR: if (wr_strobe) begin
            if (term) st <= S_DEAD;
            else begin
              ptr  <= nxt;
              used <= 1'b1;
              if (wr_accept) begin
                acc       <= 1'b1;
                stat_byte <= wr_data;
              end
            end
          end
          S_RD: if (rd_strobe) begin
            if (term) st <= S_DEAD;
            else begin
              ptr  <= nxt;
              used <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_PTR_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    sec_of({2'b00, reg_addr}) != SEC_NO); // R2
  AST_SECTION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept || rd_strobe) && !start && !stop |=> sec_of({2'b00, reg_addr}) == $past(ptr_sec)); // R3
  AST_TERM_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> $stable(reg_addr)); // R5
  AST_LATCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel); // R6
  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && reg_addr != 6'h3F |-> wel && rwel); // R7
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop)); // R8
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R8

endmodule

// File: tb/tb_ctl_addr_seq.sv
module tb_ctl_addr_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, sel_valid = 0, addr_valid = 0, wr_strobe = 0, rd_strobe = 0;
  logic [7:0] sel_byte = 0, addr_in = 0, wr_data = 0;
  logic [5:0] reg_addr;
  logic sel_ack, addr_ack, wr_accept, term, commit, wel, rwel;
  logic [2:0] commit_sec;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctl_addr_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .sel_valid(sel_valid), .sel_byte(sel_byte), .addr_valid(addr_valid), .addr_in(addr_in),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe), .reg_addr(reg_addr),
    .sel_ack(sel_ack), .addr_ack(addr_ack), .wr_accept(wr_accept), .term(term),
    .commit(commit), .commit_sec(commit_sec), .wel(wel), .rwel(rwel));

  // {start address, read count, expected pointer afterwards}
  localparam logic [15:0] VEC [8] = '{
    {6'h05, 4'd4, 6'h01}, {6'h0E, 4'd3, 6'h09}, {6'h10, 4'd3, 6'h11}, {6'h36, 4'd2, 6'h30},
    {6'h33, 4'd1, 6'h34}, {6'h07, 4'd1, 6'h00}, {6'h31, 4'd8, 6'h31}, {6'h3F, 4'd1, 6'h3F}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic do_sel(input logic [7:0] b, output logic ack);
    @(negedge clk); sel_valid = 1; sel_byte = b; #1 ack = sel_ack; @(negedge clk); sel_valid = 0;
  endtask

  task automatic do_addr(input logic [7:0] a, output logic ack);
    @(negedge clk); addr_valid = 1; addr_in = a; #1 ack = addr_ack; @(negedge clk); addr_valid = 0;
  endtask

  task automatic do_wr(input logic [7:0] d, output logic acc, output logic t);
    @(negedge clk); wr_strobe = 1; wr_data = d; #1 acc = wr_accept; t = term;
    @(negedge clk); wr_strobe = 0;
  endtask

  task automatic do_rd(output logic [5:0] a, output logic t);
    @(negedge clk); rd_strobe = 1; #1 a = reg_addr; t = term; @(negedge clk); rd_strobe = 0;
  endtask

  task automatic do_stop(output logic c, output logic [2:0] cs);
    @(negedge clk); stop = 1; @(negedge clk); c = commit; cs = commit_sec; stop = 0;
  endtask

  task automatic set_ptr(input logic [7:0] a);
    logic k, c; logic [2:0] cs;
    do_start; do_sel(8'hDE, k); do_addr(a, k); do_stop(c, cs);
  endtask

  task automatic read_first(output logic [5:0] a);
    logic k, t, c; logic [2:0] cs;
    do_start; do_sel(8'hDF, k); do_rd(a, t); do_stop(c, cs);
  endtask

  task automatic stat_write(input logic [7:0] d, output logic c, output logic [2:0] cs);
    logic k, t;
    do_start; do_sel(8'hDE, k); do_addr(8'h3F, k); do_wr(d, k, t); do_stop(c, cs);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic k, t, c; logic [2:0] cs; logic [5:0] a;
    repeat (3) @(negedge clk);
    chk("R9 reset pointer", reg_addr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset latches", {wel, rwel}, 0);
    chk("R9 reset commit", commit, 0);

    foreach (VEC[i]) begin
      set_ptr({2'b00, VEC[i][15:10]});
      do_start; do_sel(8'hDF, k);
      for (int n = 0; n < VEC[i][9:6]; n++) begin
        do_rd(a, t);
        if (n == 0) chk("R4 read starts at pointer", a, VEC[i][15:10]);
      end
      do_stop(c, cs);
      read_first(a);
      chk("R3 wrap within section", a, VEC[i][5:0]);
    end

    do_start; do_sel(8'hA0, k);
    chk("R1 foreign select refused", k, 0);
    do_addr(8'h10, k);
    chk("R1 address after foreign select ignored", k, 0);
    do_stop(c, cs);
    do_start; do_sel(8'hDE, k);
    chk("R1 matching select acknowledged", k, 1);
    do_addr(8'h20, k);
    chk("R2 address 0x20 refused", k, 0);
    do_wr(8'h55, k, t);
    chk("R2 data after refused address ignored", k, 0);
    do_stop(c, cs);
    do_start; do_sel(8'hDE, k); do_addr(8'h38, k);
    chk("R2 address 0x38 refused", k, 0);
    do_stop(c, cs);
    do_start; do_sel(8'hDE, k); do_addr(8'h11, k);
    chk("R2 address 0x11 accepted", k, 1);
    do_stop(c, cs);

    do_start; do_sel(8'hDE, k); do_addr(8'h10, k); do_wr(8'h12, k, t);
    chk("R7 write refused without latch", k, 0);
    do_stop(c, cs);
    chk("R8 no commit without accepted byte", c, 0);
    read_first(a);
    chk("R7 refused byte advances pointer", a, 6'h11);

    stat_write(8'h06, c, cs);
    chk("R6 0x06 before 0x02 leaves rwel clear", {wel, rwel}, 0);
    stat_write(8'h02, c, cs);
    chk("R8 status commit pulse", {c, cs}, {1'b1, 3'd4});
    chk("R6 0x02 sets wel", {wel, rwel}, 2'b10);
    stat_write(8'h06, c, cs);
    chk("R6 0x06 sets rwel", {wel, rwel}, 2'b11);

    do_start; do_sel(8'hDE, k); do_addr(8'h0F, k);
    do_wr(8'hA1, k, t);
    chk("R7 write accepted with latch", k, 1);
    do_wr(8'hA2, k, t);
    chk("R7 page byte after wrap accepted", k, 1);
    do_stop(c, cs);
    chk("R8 alarm 0 commit", {c, cs}, {1'b1, 3'd0});
    read_first(a);
    chk("R3 page write wraps to 0x09", a, 6'h09);

    do_start; do_sel(8'hDE, k); do_addr(8'h3F, k);
    do_wr(8'h00, k, t);
    chk("R5 first status byte accepted", {k, t}, 2'b10);
    do_wr(8'h00, k, t);
    chk("R5 second status byte terminates", {k, t}, 2'b01);
    do_stop(c, cs);
    chk("R5 no commit after termination", c, 0);
    chk("R5 latch untouched after termination", {wel, rwel}, 2'b11);

    do_start; do_sel(8'hDF, k);
    do_rd(a, t);
    chk("R5 first status read", {a, t}, {6'h3F, 1'b0});
    do_rd(a, t);
    chk("R5 second status read terminates", t, 1);
    do_stop(c, cs);

    do_start; do_sel(8'hDE, k); do_addr(8'h30, k); do_wr(8'h11, k, t);
    do_start; do_stop(c, cs);
    chk("R8 repeated start aborts commit", c, 0);

    do_start; do_sel(8'hDE, k); do_addr(8'h32, k);
    @(negedge clk); stop = 1; wr_strobe = 1; wr_data = 8'h44; #1 k = wr_accept;
    @(negedge clk); c = commit; stop = 0; wr_strobe = 0;
    chk("R8 strobe with stop not accepted", k, 0);
    chk("R8 strobe with stop gives no commit", c, 0);
    read_first(a);
    chk("R8 strobe with stop leaves pointer", a, 6'h32);

    stat_write(8'h00, c, cs);
    chk("R6 0x00 clears both", {wel, rwel}, 0);
    do_start; do_sel(8'hDE, k); do_addr(8'h00, k); do_wr(8'h01, k, t);
    chk("R7 write refused after clear", k, 0);
    do_stop(c, cs);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule